// File: doc/BRIEF.md
# Random Number Buffer Register Front End

This block is the register face of a hardware random number generator. An external entropy source offers 32-bit words one at a time with a valid signal. The block collects them into a four-word output buffer, with a programmable minimum spacing between accepted words and a programmable timeout. When the buffer is full it raises a ready flag and freezes the buffer until software reads the words and writes a one to the ready bit, which starts the next block.

Alongside the buffer it keeps a sticky event register fed by pulses from outside health-test and oscillator-alarm logic. Each event bit is cleared by writing one to it. A control register holds the generation enable and one interrupt enable per event. A single interrupt line is high while any enabled event is pending. A read-only revision word completes the map. Software reaches everything through a plain 32-bit read/write bus with a combinational read path.

Top module: `rng_csr_frontend`

## Requirements
- R1: After reset, every register reads zero except the revision word, and irq and src_ready are low.
- R2: Buffer words read at offsets 0x00, 0x04, 0x08 and 0x0C, in order of arrival: the first accepted word is at 0x00. Reads of unmapped offsets return zero.
- R3: The ready flag is bit 0 of the status register at 0x10. It rises only in the cycle after the fourth word of a block has been accepted.
- R4: While ready is high, src_ready stays low and the four buffer words do not change, whatever the source drives.
- R5: Writing 1 to status bit 0 while ready is high clears ready and restarts collection at word 0. Writing 0 there has no effect.
- R6: Event pulses set sticky status bits: bit 1 shutdown overflow, bit 2 stuck output, bit 3 noise, bit 4 run, bit 5 long run, bit 6 poker, bit 7 monobit. Writing 1 clears a bit and writing 0 leaves it alone. An event arriving in the same cycle as its clear keeps the bit set.
- R7: The control register at 0x14 holds the enable in bit 10 and the interrupt enables in bits 7:1. All other bits read 0. With the enable low, no source word is accepted.
- R8: irq is high exactly when some status bit among 7:1 is set together with the enable bit in the same position. Ready never raises irq.
- R9: The configuration register at 0x18 holds the maximum refill gap in bits 31:16 and the minimum gap in bits 7:0, with other bits reading 0. A word is accepted only after at least the minimum number of idle cycles since the block started or since the previous word. With the source always valid, ready therefore rises (min+1)*4 cycles after a release.
- R10: If max is nonzero and the gap count reaches max with no word accepted, the partial block is dropped, collection restarts at word 0, and stall goes high until the next accepted word. A max of 0 disables the timeout.
- R11: Offset 0x7C reads the revision: major in bits 27:24, minor in 23:20, patch in 19:16, all else 0. Writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| src_valid | input | 1 | Entropy source offers a word |
| src_word | input | 32 | Offered word |
| src_ready | output | 1 | Word is taken at this edge if valid |
| evt_pulse | input | 7 | Event pulses for status bits 7:1 |
| irq | output | 1 | Interrupt request |
| stall | output | 1 | Refill timed out; cleared by the next accepted word |

## Verification
The bench offers source words while the buffer is full and checks that none slips in. A design that overwrote a frozen buffer would show changed words at 0x00. It clears events in the same cycle a pulse arrives, where a clear-wins design would lose the event. It also writes zeros to the status register, which a plain-write design would use to wipe pending bits. The refill latency is measured against the minimum-gap formula, where an off-by-one gap counter shifts the ready edge by four cycles. Finally, a partial block is abandoned through the timeout, and the next block must start at word 0 rather than continue at the stale index.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
  localparam int OFS_STATUS  = 'h10;
  localparam int OFS_CONTROL = 'h14;
  localparam int OFS_CONFIG  = 'h18;
  localparam int OFS_REV     = 'h7C;
  localparam int CTL_EN_BIT  = 10;
  localparam int EVT_LO      = 1;
  localparam int EVT_HI      = 7;
endpackage

// File: rtl/rng_rst_sync.sv
module rng_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rng_fill_engine.sv
module rng_fill_engine #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int MIN_W   = 8,
  parameter int GAP_W   = 16,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [MIN_W-1:0]               min_gap,
  input  logic [GAP_W-1:0]               max_gap,
  input  logic                           release_i,
  input  logic                           src_valid,
  input  logic [WORD_W-1:0]              src_word,
  output logic                           src_ready,
  output logic [N_WORDS-1:0][WORD_W-1:0] words,
  output logic                           ready,
  output logic                           stall,
  output logic                           accept
);
  logic [N_WORDS-1:0][WORD_W-1:0] words_q, words_d;
  logic [IDX_W-1:0]               idx_q, idx_d;
  logic [GAP_W-1:0]               gap_q, gap_d;
  logic                           ready_q, ready_d;
  logic                           stall_q, stall_d;
  logic                           collecting, gap_met, timeout;

  assign collecting = en && !ready_q;
  assign gap_met    = gap_q >= GAP_W'(min_gap);
  assign src_ready  = collecting && gap_met;
  assign accept     = src_ready && src_valid;
  assign timeout    = collecting && !accept && (max_gap != '0) && (gap_q >= max_gap);

  always_comb begin
    words_d = words_q;
    idx_d   = idx_q;
    gap_d   = gap_q;
    ready_d = ready_q;
    stall_d = stall_q;
    if (release_i && ready_q) begin
      ready_d = 1'b0;
      idx_d   = '0;
      gap_d   = '0;
    end else if (accept) begin
      words_d[idx_q] = src_word;
      gap_d          = '0;
      stall_d        = 1'b0;
      if (idx_q == IDX_W'(N_WORDS - 1)) begin
        ready_d = 1'b1;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (timeout) begin
      idx_d   = '0;
      gap_d   = '0;
      stall_d = 1'b1;
    end else if (collecting && (gap_q != '1)) begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      ready_q <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      words_q <= words_d;
      idx_q   <= idx_d;
      gap_q   <= gap_d;
      ready_q <= ready_d;
      stall_q <= stall_d;
    end
  end

  assign words = words_q;
  assign ready = ready_q;
  assign stall = stall_q;
endmodule

// File: rtl/rng_event_status.sv
module rng_event_status #(
  parameter int EVT_LO = 1,
  parameter int EVT_HI = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_HI:EVT_LO] evt_set,
  input  logic              clr_en,
  input  logic [EVT_HI:EVT_LO] clr_mask,
  input  logic [EVT_HI:EVT_LO] int_en,
  output logic [EVT_HI:EVT_LO] status,
  output logic              irq
);
  logic [EVT_HI:EVT_LO] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (clr_en) status_d = status_d & ~clr_mask;
    status_d = status_d | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;
  assign irq    = |(status_q & int_en);
endmodule

// File: rtl/rng_csr_frontend.sv
module rng_csr_frontend
  import rng_csr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int N_WORDS   = 4,
  parameter int MIN_W     = 8,
  parameter int GAP_W     = 16,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  parameter int REV_PATCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_word,
  output logic              src_ready,
  input  logic [EVT_HI:EVT_LO] evt_pulse,
  output logic              irq,
  output logic              stall
);
  localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int BUF_SPAN = N_WORDS * 4;
  localparam logic [WORD_W-1:0] REV_WORD =
    WORD_W'((REV_MAJOR & 'hF) << 24) | WORD_W'((REV_MINOR & 'hF) << 20) |
    WORD_W'((REV_PATCH & 'hF) << 16);

  logic rst_sync_n;
  logic wr_stb, rd_stb;
  logic sts_wr, ctl_wr, cfg_wr;
  logic ctl_en_q, ctl_en_d;
  logic [EVT_HI:EVT_LO] ctl_ie_q, ctl_ie_d;
  logic [GAP_W-1:0] cfg_max_q, cfg_max_d;
  logic [MIN_W-1:0] cfg_min_q, cfg_min_d;
  logic [N_WORDS-1:0][WORD_W-1:0] buf_words;
  logic buf_ready, fill_accept;
  logic [EVT_HI:EVT_LO] evt_status;
  logic [WORD_W-1:0] rd_mux;

  rng_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;
  assign sts_wr = wr_stb && (bus_addr == ADDR_W'(OFS_STATUS));
  assign ctl_wr = wr_stb && (bus_addr == ADDR_W'(OFS_CONTROL));
  assign cfg_wr = wr_stb && (bus_addr == ADDR_W'(OFS_CONFIG));

  always_comb begin
    ctl_en_d  = ctl_en_q;
    ctl_ie_d  = ctl_ie_q;
    cfg_max_d = cfg_max_q;
    cfg_min_d = cfg_min_q;
    if (ctl_wr) begin
      ctl_en_d = bus_wdata[CTL_EN_BIT];
      ctl_ie_d = bus_wdata[EVT_HI:EVT_LO];
    end
    if (cfg_wr) begin
      cfg_max_d = bus_wdata[16 +: GAP_W];
      cfg_min_d = bus_wdata[MIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_en_q  <= 1'b0;
      ctl_ie_q  <= '0;
      cfg_max_q <= '0;
      cfg_min_q <= '0;
    end else begin
      ctl_en_q  <= ctl_en_d;
      ctl_ie_q  <= ctl_ie_d;
      cfg_max_q <= cfg_max_d;
      cfg_min_q <= cfg_min_d;
    end
  end

  rng_fill_engine #(
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .MIN_W(MIN_W), .GAP_W(GAP_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_sync_n), .en(ctl_en_q),
    .min_gap(cfg_min_q), .max_gap(cfg_max_q),
    .release_i(sts_wr && bus_wdata[0]),
    .src_valid(src_valid), .src_word(src_word), .src_ready(src_ready),
    .words(buf_words), .ready(buf_ready), .stall(stall), .accept(fill_accept)
  );

  rng_event_status #(.EVT_LO(EVT_LO), .EVT_HI(EVT_HI)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .evt_set(evt_pulse),
    .clr_en(sts_wr), .clr_mask(bus_wdata[EVT_HI:EVT_LO]),
    .int_en(ctl_ie_q), .status(evt_status), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if ((bus_addr < ADDR_W'(BUF_SPAN)) && (bus_addr[1:0] == 2'b00)) begin
      rd_mux = buf_words[bus_addr[IDX_W+1:2]];
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_STATUS): begin
          rd_mux[0]             = buf_ready;
          rd_mux[EVT_HI:EVT_LO] = evt_status;
        end
        ADDR_W'(OFS_CONTROL): begin
          rd_mux[CTL_EN_BIT]    = ctl_en_q;
          rd_mux[EVT_HI:EVT_LO] = ctl_ie_q;
        end
        ADDR_W'(OFS_CONFIG): begin
          rd_mux[16 +: GAP_W]   = cfg_max_q;
          rd_mux[MIN_W-1:0]     = cfg_min_q;
        end
        ADDR_W'(OFS_REV): rd_mux = REV_WORD;
        default: rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata = rd_stb ? rd_mux : '0;
endmodule

// File: rtl/rng_csr_checker.sv
module rng_csr_checker #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ready,
  input logic [N_WORDS-1:0][WORD_W-1:0] words,
  input logic                           src_ready,
  input logic                           accept,
  input logic                           stall,
  input logic [7:1]                     evt_status,
  input logic                           sts_wr,
  input logic                           irq,
  input logic [7:1]                     ctl_ie,
  input logic                           ctl_en
);
  a_r4_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(words));

  a_r4_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !src_ready);

  a_r3_ready_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(accept));

  a_r6_sticky_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> (($past(evt_status) & ~evt_status) == 7'd0));

  a_r7_disabled_blocks_source: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !src_ready);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ie == 7'd0) |-> !irq);

  a_r10_stall_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> (!ready && !$past(accept)));
endmodule

bind rng_csr_frontend rng_csr_checker #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ready(buf_ready), .words(buf_words),
  .src_ready(src_ready), .accept(fill_accept), .stall(stall),
  .evt_status(evt_status), .sts_wr(sts_wr), .irq(irq),
  .ctl_ie(ctl_ie_q), .ctl_en(ctl_en_q)
);

// File: tb/sim_rng_csr_frontend.sv
`timescale 1ns/1ps
module sim_rng_csr_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic        src_ready;
  logic [7:1]  evt_pulse = '0;
  logic        irq, stall;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rng_csr_frontend u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_valid(src_valid), .src_word(src_word), .src_ready(src_ready),
    .evt_pulse(evt_pulse), .irq(irq), .stall(stall)
  );

  // address, write data, expected read-back after the write
  localparam logic [95:0] VEC [0:5] = '{
    {32'h14, 32'hFFFF_FFFF, 32'h0000_04FE},  // R7
    {32'h14, 32'h0000_0000, 32'h0000_0000},  // R7
    {32'h18, 32'hFFFF_FFFF, 32'hFFFF_00FF},  // R9
    {32'h18, 32'h1234_5678, 32'h1234_0078},  // R9
    {32'h7C, 32'hFFFF_FFFF, 32'h0213_0000},  // R11
    {32'h40, 32'hFFFF_FFFF, 32'h0000_0000}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    src_valid = 1'b1; src_word = w;
    while (!src_ready) @(negedge clk);
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic fire(input logic [7:1] m);
    @(negedge clk);
    evt_pulse = m;
    @(posedge clk); #1;
    evt_pulse = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    rd(8'h10, v); check("R1 status", v, 32'h0);
    rd(8'h14, v); check("R1 control", v, 32'h0);
    rd(8'h18, v); check("R1 config", v, 32'h0);
    rd(8'h00, v); check("R1 word0", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 src_ready", {31'b0, src_ready}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check("R7/R9/R11/R2 table", v, VEC[i][31:0]);
    end

    // R3, R2: collect a block
    wr(8'h18, 32'h0);
    wr(8'h14, 32'h400);
    push(32'hA000_0000); push(32'hA000_0001); push(32'hA000_0002);
    rd(8'h10, v); check("R3 not ready after three", v & 32'h1, 32'h0);
    push(32'hA000_0003);
    rd(8'h10, v); check("R3 ready after four", v & 32'h1, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd(8'(i * 4), v); check("R2 word order", v, 32'hA000_0000 + i);
    end
    check("R8 ready alone no irq", {31'b0, irq}, 32'h0);

    // R4 frozen buffer
    check("R4 src_ready low", {31'b0, src_ready}, 32'h0);
    @(negedge clk); src_valid = 1'b1; src_word = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    src_valid = 1'b0;
    rd(8'h00, v); check("R4 word0 kept", v, 32'hA000_0000);
    rd(8'h0C, v); check("R4 word3 kept", v, 32'hA000_0003);

    // R5 release
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R5 zero write keeps ready", v & 32'h1, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, v); check("R5 ready cleared", v & 32'h1, 32'h0);
    for (int i = 0; i < 4; i++) push(32'hB000_0000 + i);
    rd(8'h00, v); check("R5 refill word0", v, 32'hB000_0000);
    rd(8'h0C, v); check("R5 refill word3", v, 32'hB000_0003);

    // R6, R8 events
    fire(7'b0100000);  // bit 6
    rd(8'h10, v); check("R6 poker sticky", v, 32'h41);
    check("R8 masked no irq", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h440);
    check("R8 enabled irq", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R6 zero write no clear", v, 32'h41);
    wr(8'h10, 32'h40);
    rd(8'h10, v); check("R6 w1c", v, 32'h01);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
    @(negedge clk);
    evt_pulse = 7'b0000010;  // bit 2
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h04;
    @(posedge clk); #1;
    evt_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h10, v); check("R6 set wins over clear", v, 32'h05);
    wr(8'h10, 32'h04);
    rd(8'h10, v); check("R6 clear bit2", v, 32'h01);

    // R9 minimum gap timing
    wr(8'h14, 32'h400);
    wr(8'h18, 32'h0000_0002);
    @(negedge clk); src_valid = 1'b1; src_word = 32'hC0C0_C0C0;
    wr(8'h10, 32'h1);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!(u0.bus_rdata === 32'h0 && 1'b0) && n < 100 && !ready_seen());
    src_valid = 1'b0;
    check("R9 min gap latency", n, 32'd12);
    check("R10 no stall with max 0", {31'b0, stall}, 32'h0);

    // R7 enable low blocks
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h10, 32'h1);
    @(negedge clk); src_valid = 1'b1; src_word = 32'h1111_1111;
    repeat (8) @(negedge clk);
    check("R7 disabled no src_ready", {31'b0, src_ready}, 32'h0);
    src_valid = 1'b0;
    rd(8'h10, v); check("R7 disabled stays empty", v & 32'h1, 32'h0);

    // R10 timeout
    wr(8'h14, 32'h400);
    wr(8'h18, 32'h0003_0000);
    push(32'hE000_0000); push(32'hE000_0001);
    check("R10 stall clear after accept", {31'b0, stall}, 32'h0);
    repeat (8) @(negedge clk);
    check("R10 stall after timeout", {31'b0, stall}, 32'h1);
    for (int i = 0; i < 4; i++) push(32'hD000_0000 + i);
    rd(8'h10, v); check("R10 block completes", v & 32'h1, 32'h1);
    rd(8'h00, v); check("R10 restart at word0", v, 32'hD000_0000);
    check("R10 stall cleared", {31'b0, stall}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  // ready is observed through a status read on the bus lines without a clock
  function automatic bit ready_seen();
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10;
    ready_seen = 1'b0;
    return ready_peek;
  endfunction

  logic ready_peek;
  always_comb ready_peek = bus_rdata[0];
endmodule